// File: doc/BRIEF.md
# PHY Timing Programming Sequencer

This block programs a serial-display PHY through its narrow test port. A single start pulse hands it the per-lane bit rate in Mbps and the PLL input divider N and feedback divider M. The block captures these operands and then makes seventeen register writes in a fixed order. Each write shifts a code byte and then a data byte through a two-phase strobe. Once the final write is done it pulses `done` for one cycle.

The data bytes are worked out from the captured operands as the run proceeds. The VCO band code comes from the rate. The divider fields come from N and M. Eleven lane timing fields come from nanosecond targets, converted to byte-clock cycles or to unit intervals with ceiling rounding. A single converter serves all of them, because only one write is on the port at a time.

Top module: `phy_tseq`

## Requirements
- R1: In reset and when idle, `tst_clk` is 1, `tst_en` is 0, `tst_din` is 0 and `done` is 0. A reset during a run returns the block to this idle state, and no `done` follows.
- R2: Every write takes four cycles. In cycle 1, clk=1, en=1 and din=code. In cycle 2, clk=0, en=1 and din=code, so the code is captured on the falling edge of `tst_clk` while `tst_en` is high. In cycle 3, clk=0, en=0 and din=data. In cycle 4, clk=1, en=0 and din=data, so the data is captured on the rising edge of `tst_clk` while `tst_en` is low.
- R3: A start accepted at clock edge k puts the first write on the port from edge k+1. The 17 codes follow in this order: 0x10, 0x17, 0x18, 0x19, 0x18, 0x19, 0x60 through 0x65, then 0x70 through 0x74.
- R4: The data for code 0x10 is 0x80 | (v << 3). The value v is 0 when the rate is below 200; otherwise it is (rate+100)/200, capped at 7.
- R5: Code 0x17 carries (N−1) in bits [6:0]. The first 0x18 write carries (M−1) bits [4:0]. The second 0x18 write carries 0x80 | (((M−1)>>5) & 0xF). Each of these two 0x18 writes is followed at once by 0x19 with data 0x30.
- R6: A byte-clock count of ns is ceil(floor(ns·rate/8)/1000).
- R7: A unit-interval count of ns is ceil(ns·rate/1000).
- R8: The clock-lane values are:
  - 0x60: 500 ns in byte clocks
  - 0x61: 40 ns in UI
  - 0x62: 300 ns in byte clocks
  - 0x63: 100 ns in UI
  - 0x64: 100 ns in byte clocks
  - 0x65: 60 ns in byte clocks, plus 7
- R9: The data-lane values are:
  - 0x70: 500 ns in byte clocks
  - 0x71: 50 ns in UI, plus 20
  - 0x72: 140 ns in byte clocks, plus 2
  - 0x73: 60 ns in UI, plus 8
  - 0x74: 100 ns in byte clocks
- R10: Each timing value carries a flag. Bit 7 is set for 0x60, 0x61, 0x63, 0x70, 0x71 and 0x73, and those values saturate at 127. Bit 6 is set for 0x62 and 0x72, and those values saturate at 63. Bit 5 is set for 0x64, 0x65 and 0x74, and those values saturate at 31.
- R11: `done` is high for exactly one cycle, at clock edge k+69 after a start accepted at edge k.
- R12: A start that arrives during a run is ignored. The run's writes keep the operands captured at its own start, and exactly one `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse; operands sampled with it |
| rate_mbps | input | 11 | Per-lane bit rate in Mbps |
| in_div | input | 8 | PLL input divider N (1 or more) |
| fb_div | input | 10 | PLL feedback divider M (1 or more) |
| tst_clk | output | 1 | Test-port strobe |
| tst_en | output | 1 | Test-port code/data select (1 = code) |
| tst_din | output | 8 | Test-port byte |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bound checker watches the test-port strobe protocol on every cycle. It checks that the strobe falls only while the code is selected, rises only while data is selected, and stays at idle levels outside a run. It also checks that a run cannot stop before its last beat and that `done` is a lone pulse that ends a run. The arithmetic needs the bench's scenarios: the VCO band edges, N and M at their extremes, ceiling rounding and field saturation at high rates, all compared against the bytes captured from the port. The same goes for the fixed write order, the exact `done` latency, a start ignored mid-run, and a reset that aborts a run.

// File: rtl/phy_tseq_pkg.sv
package phy_tseq_pkg;

    localparam int NSTEPS    = 17;
    localparam int ROUND_DIV = 1000;

    typedef enum logic [2:0] {
        K_VCO, K_INDIV, K_FBLO, K_DIVEN, K_FBHI, K_TMG
    } step_kind_e;

    typedef enum logic [1:0] {
        EN_B7, EN_B6, EN_B5
    } en_pos_e;

    typedef struct packed {
        logic [9:0] ns;
        logic       ui;
        logic [4:0] add;
        en_pos_e    en;
    } tmg_t;

    typedef struct packed {
        step_kind_e kind;
        logic [7:0] code;
        tmg_t       tmg;
    } step_t;

    function automatic step_t mk(input step_kind_e k, input logic [7:0] c,
                                 input int ns, input logic ui, input int add,
                                 input en_pos_e en);
        step_t s;
        s.kind    = k;
        s.code    = c;
        s.tmg.ns  = 10'(ns);
        s.tmg.ui  = ui;
        s.tmg.add = 5'(add);
        s.tmg.en  = en;
        return s;
    endfunction

    function automatic step_t step_at(input logic [4:0] idx);
        case (idx)
            5'd0:  return mk(K_VCO,   8'h10,   0, 1'b0,  0, EN_B7);
            5'd1:  return mk(K_INDIV, 8'h17,   0, 1'b0,  0, EN_B7);
            5'd2:  return mk(K_FBLO,  8'h18,   0, 1'b0,  0, EN_B7);
            5'd3:  return mk(K_DIVEN, 8'h19,   0, 1'b0,  0, EN_B7);
            5'd4:  return mk(K_FBHI,  8'h18,   0, 1'b0,  0, EN_B7);
            5'd5:  return mk(K_DIVEN, 8'h19,   0, 1'b0,  0, EN_B7);
            5'd6:  return mk(K_TMG,   8'h60, 500, 1'b0,  0, EN_B7);
            5'd7:  return mk(K_TMG,   8'h61,  40, 1'b1,  0, EN_B7);
            5'd8:  return mk(K_TMG,   8'h62, 300, 1'b0,  0, EN_B6);
            5'd9:  return mk(K_TMG,   8'h63, 100, 1'b1,  0, EN_B7);
            5'd10: return mk(K_TMG,   8'h64, 100, 1'b0,  0, EN_B5);
            5'd11: return mk(K_TMG,   8'h65,  60, 1'b0,  7, EN_B5);
            5'd12: return mk(K_TMG,   8'h70, 500, 1'b0,  0, EN_B7);
            5'd13: return mk(K_TMG,   8'h71,  50, 1'b1, 20, EN_B7);
            5'd14: return mk(K_TMG,   8'h72, 140, 1'b0,  2, EN_B6);
            5'd15: return mk(K_TMG,   8'h73,  60, 1'b1,  8, EN_B7);
            default: return mk(K_TMG, 8'h74, 100, 1'b0,  0, EN_B5);
        endcase
    endfunction

endpackage

// File: rtl/phy_tseq_conv.sv
module phy_tseq_conv
    import phy_tseq_pkg::*;
#(
    parameter int RATE_W = 11
) (
    input  logic [RATE_W-1:0] rate,
    input  tmg_t              tmg,
    output logic [7:0]        field
);
    localparam int PW = RATE_W + 12;

    logic [PW-1:0] prod, scaled, cyc, lim;
    logic [7:0]    flag;

    always_comb begin
        prod   = PW'(tmg.ns) * PW'(rate);
        scaled = tmg.ui ? prod : (prod >> 3);
        cyc    = (scaled + PW'(ROUND_DIV - 1)) / PW'(ROUND_DIV) + PW'(tmg.add);
        case (tmg.en)
            EN_B7:   begin flag = 8'h80; lim = PW'(127); end
            EN_B6:   begin flag = 8'h40; lim = PW'(63);  end
            default: begin flag = 8'h20; lim = PW'(31);  end
        endcase
        field = flag | ((cyc > lim) ? lim[7:0] : cyc[7:0]);
    end
endmodule

// File: rtl/phy_tseq_port.sv
module phy_tseq_port (
    input  logic       run,
    input  logic [1:0] ph,
    input  logic [7:0] code,
    input  logic [7:0] data,
    output logic       tclk,
    output logic       ten,
    output logic [7:0] din
);
    always_comb begin
        if (!run) begin
            tclk = 1'b1; ten = 1'b0; din = 8'h00;
        end else begin
            case (ph)
                2'd0:    begin tclk = 1'b1; ten = 1'b1; din = code; end
                2'd1:    begin tclk = 1'b0; ten = 1'b1; din = code; end
                2'd2:    begin tclk = 1'b0; ten = 1'b0; din = data; end
                default: begin tclk = 1'b1; ten = 1'b0; din = data; end
            endcase
        end
    end
endmodule

// File: rtl/phy_tseq.sv
module phy_tseq
    import phy_tseq_pkg::*;
#(
    parameter int RATE_W = 11,
    parameter int NDIV_W = 8,
    parameter int MDIV_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [RATE_W-1:0] rate_mbps,
    input  logic [NDIV_W-1:0] in_div,
    input  logic [MDIV_W-1:0] fb_div,
    output logic              tst_clk,
    output logic              tst_en,
    output logic [7:0]        tst_din,
    output logic              done
);
    localparam int IDX_W = $clog2(NSTEPS);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NSTEPS - 1);

    logic              run_q;
    logic [IDX_W-1:0]  idx_q;
    logic [1:0]        ph_q;
    logic [RATE_W-1:0] rate_q;
    logic [NDIV_W-1:0] n_q;
    logic [MDIV_W-1:0] m_q;
    logic              final_beat;

    step_t             step;
    logic [7:0]        tmg_field, data;
    logic [RATE_W:0]   vsum, vq;
    logic [2:0]        vco;
    logic [MDIV_W-1:0] m1;

    assign final_beat = run_q && (idx_q == LAST) && (ph_q == 2'd3);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            idx_q  <= '0;
            ph_q   <= '0;
            done   <= 1'b0;
            rate_q <= '0;
            n_q    <= '0;
            m_q    <= '0;
        end else begin
            done <= 1'b0;
            if (!run_q) begin
                if (start) begin
                    run_q  <= 1'b1;
                    idx_q  <= '0;
                    ph_q   <= '0;
                    rate_q <= rate_mbps;
                    n_q    <= in_div;
                    m_q    <= fb_div;
                end
            end else begin
                ph_q <= ph_q + 2'd1;
                if (final_beat) begin
                    run_q <= 1'b0;
                    done  <= 1'b1;
                end else if (ph_q == 2'd3) begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    assign step = step_at(5'(idx_q));

    phy_tseq_conv #(.RATE_W(RATE_W)) u_conv (
        .rate  (rate_q),
        .tmg   (step.tmg),
        .field (tmg_field)
    );

    always_comb begin
        vsum = {1'b0, rate_q} + (RATE_W+1)'(100);
        vq   = vsum / (RATE_W+1)'(200);
        if ({1'b0, rate_q} < (RATE_W+1)'(200)) vco = 3'd0;
        else if (vq > (RATE_W+1)'(7))          vco = 3'd7;
        else                                   vco = vq[2:0];
        m1 = m_q - MDIV_W'(1);
        case (step.kind)
            K_VCO:   data = 8'h80 | {2'b00, vco, 3'b000};
            K_INDIV: data = {1'b0, 7'(n_q - NDIV_W'(1))};
            K_FBLO:  data = {3'b000, m1[4:0]};
            K_FBHI:  data = 8'h80 | {4'b0000, 4'(m1 >> 5)};
            K_DIVEN: data = 8'h30;
            default: data = tmg_field;
        endcase
    end

    phy_tseq_port u_port (
        .run  (run_q),
        .ph   (ph_q),
        .code (step.code),
        .data (data),
        .tclk (tst_clk),
        .ten  (tst_en),
        .din  (tst_din)
    );
endmodule

// File: rtl/phy_tseq_chk.sv
module phy_tseq_chk (
    input logic clk,
    input logic rst,
    input logic run,
    input logic final_beat,
    input logic done,
    input logic tclk,
    input logic ten
);
    // R1
    idle_pins_chk: assert property (@(posedge clk) disable iff (rst)
        !run |-> (tclk && !ten));
    // R2
    code_latch_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(tclk) |-> ten);
    // R2
    data_prog_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tclk) |-> !ten);
    // R2
    en_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ten) |-> !tclk);
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R11
    done_ends_run_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!run && $past(run)));
    // R12
    run_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !final_beat) |=> run);
endmodule

bind phy_tseq phy_tseq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .run        (run_q),
    .final_beat (final_beat),
    .done       (done),
    .tclk       (tst_clk),
    .ten        (tst_en)
);

// File: tb/phy_tseq_test.sv
module phy_tseq_test;
    localparam int NW = 17;
    localparam int NV = 6;
    localparam int VEC [NV][3] = '{
        '{  80,   1, 100},
        '{ 199,   3, 200},
        '{ 200,   2,  64},
        '{1000,  27, 511},
        '{1500, 128, 512},
        '{2047,   5,  33}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [10:0] rate_mbps = '0;
    logic [7:0]  in_div = '0;
    logic [9:0]  fb_div = '0;
    logic        tst_clk, tst_en, done;
    logic [7:0]  tst_din;

    int checks = 0;
    int fails  = 0;
    int nlog   = 0;
    int ndone  = 0;
    int log_code [64];
    int log_data [64];
    int cur_code = 0;
    logic prev_clk = 1'b1;

    always #2.5 clk = ~clk;

    phy_tseq uut (
        .clk(clk), .rst(rst), .start(start), .rate_mbps(rate_mbps),
        .in_div(in_div), .fb_div(fb_div), .tst_clk(tst_clk),
        .tst_en(tst_en), .tst_din(tst_din), .done(done)
    );

    always @(negedge clk) begin
        if (prev_clk && !tst_clk && tst_en) cur_code = tst_din;
        if (!prev_clk && tst_clk && !tst_en && nlog < 64) begin
            log_code[nlog] = cur_code;
            log_data[nlog] = tst_din;
            nlog = nlog + 1;
        end
        if (done) ndone = ndone + 1;
        prev_clk = tst_clk;
    end

    task automatic check(input int act, input int exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int sat(input int v, input int lim);
        return (v > lim) ? lim : v;
    endfunction

    function automatic int bcy(input int ns, input int r);
        return ((ns * r) / 8 + 999) / 1000;
    endfunction

    function automatic int uiv(input int ns, input int r);
        return (ns * r + 999) / 1000;
    endfunction

    function automatic int exp_code(input int i);
        case (i)
            0: return 'h10; 1: return 'h17; 2: return 'h18; 3: return 'h19;
            4: return 'h18; 5: return 'h19;
            default: return (i < 12) ? ('h60 + i - 6) : ('h70 + i - 12);
        endcase
    endfunction

    function automatic int exp_data(input int i, input int r, input int n, input int m);
        int v;
        case (i)
            0: begin
                v = (r < 200) ? 0 : sat((r + 100) / 200, 7);
                return 'h80 | (v << 3);
            end
            1:  return (n - 1) & 'h7f;
            2:  return (m - 1) & 'h1f;
            3:  return 'h30;
            4:  return 'h80 | (((m - 1) >> 5) & 'hf);
            5:  return 'h30;
            6:  return 'h80 | sat(bcy(500, r), 127);      // R8
            7:  return 'h80 | sat(uiv(40, r), 127);
            8:  return 'h40 | sat(bcy(300, r), 63);
            9:  return 'h80 | sat(uiv(100, r), 127);
            10: return 'h20 | sat(bcy(100, r), 31);
            11: return 'h20 | sat(bcy(60, r) + 7, 31);
            12: return 'h80 | sat(bcy(500, r), 127);      // R9
            13: return 'h80 | sat(uiv(50, r) + 20, 127);
            14: return 'h40 | sat(bcy(140, r) + 2, 63);
            15: return 'h80 | sat(uiv(60, r) + 8, 127);
            default: return 'h20 | sat(bcy(100, r), 31);
        endcase
    endfunction

    // Launch a run; optionally pulse a second start mid-run (R12).
    task automatic run_one(input int r, input int n, input int m,
                           input bit poke, output int lat);
        int c;
        @(negedge clk);
        nlog = 0; ndone = 0; lat = -1;
        rate_mbps = 11'(r); in_div = 8'(n); fb_div = 10'(m);
        start = 1'b1;
        c = 0;
        while (c < 150) begin
            @(negedge clk);
            c++;
            start = 1'b0;
            if (poke && c == 20) begin
                start = 1'b1;
                rate_mbps = 11'd1234; in_div = 8'd9; fb_div = 10'd300;
            end
            if (done && lat < 0) lat = c;
        end
    endtask

    task automatic compare_run(input int r, input int n, input int m, input int lat);
        check(nlog, NW, "R3 write count");
        for (int i = 0; i < NW && i < nlog; i++) begin
            check(log_code[i], exp_code(i), "R3 code order");
            if (i == 0) check(log_data[i], exp_data(i, r, n, m), "R4 vco");
            else if (i < 6) check(log_data[i], exp_data(i, r, n, m), "R5 dividers");
            else check(log_data[i], exp_data(i, r, n, m), "R6 R7 R10 timing");
        end
        check(lat, 69, "R11 done latency");
        check(ndone, 1, "R11 done count");
    endtask

    initial begin
        int lat;
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(tst_clk, 1, "R1 reset clk");
        check(tst_en, 0, "R1 reset en");
        check(tst_din, 0, "R1 reset din");
        check(done, 0, "R1 reset done");
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            run_one(VEC[v][0], VEC[v][1], VEC[v][2], 1'b0, lat);
            compare_run(VEC[v][0], VEC[v][1], VEC[v][2], lat);
        end

        // Literal corner values
        run_one(1000, 27, 511, 1'b0, lat);
        check(log_data[6], 'hBF, "R8 request at 1000");
        check(log_data[11], 'h2F, "R8 post at 1000");
        run_one(2047, 5, 33, 1'b0, lat);
        check(log_data[8], 'h7F, "R10 zero saturates");
        check(log_data[9], 'hFF, "R10 trail saturates");
        check(log_data[0], 'hB8, "R4 vco capped");
        check(log_data[4], 'h81, "R5 high field");
        run_one(200, 2, 64, 1'b0, lat);
        check(log_data[0], 'h88, "R4 vco at 200");
        check(log_data[14], 'h40 | 6, "R9 data zero at 200");
        run_one(1500, 128, 512, 1'b0, lat);
        check(log_data[1], 'h7F, "R5 input divider max");
        check(log_data[2], 'h1F, "R5 low field");

        // R12 start during a run is ignored
        run_one(500, 4, 150, 1'b1, lat);
        compare_run(500, 4, 150, lat);

        // R1 reset mid-run returns to idle with no done
        @(negedge clk);
        ndone = 0;
        start = 1'b1; rate_mbps = 11'd800;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(tst_clk, 1, "R1 abort clk");
        check(tst_en, 0, "R1 abort en");
        repeat (80) @(negedge clk);
        check(ndone, 0, "R1 no done after abort");
        check(tst_din, 0, "R1 idle din");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule